// File: doc/BRIEF.md
# Serial configuration loader

This block loads a programmable logic target over a slave-serial link, reading the bitstream from a local byte-wide memory instead of a dedicated configuration memory chip. A start request first drives the active-low program line low for a fixed number of cycles and then releases it. The block then waits until the target's open-drain init line reads high, which means the target has finished clearing itself.

After that it serialises the bitstream, most significant bit of each byte first. It produces exactly one rising edge of a gated configuration clock per bit. The clock comes from a parameterised divider and only runs while bits or trailing edges are being sent. Once the last bit has gone out, a fixed number of extra edges follows with the data line held high. The block then watches the open-drain done line. If done goes high the load has succeeded. If init or done does not arrive within its timeout, the load has failed. Init and done each pass through a two-flop synchroniser before use. One byte is always prefetched from the memory's registered read port, so the clock never pauses between bytes.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the program line is high, the configuration clock is low, and busy, ok and err are all low.
- R2: A start request drives the program line low for exactly PROG_CYCLES system cycles. Busy goes high on the cycle after the request and stays high until ok or err is raised.
- R3: No rising edge of the configuration clock occurs while the program line is low or while init reads low. If init does not read high within INIT_TIMEOUT cycles after the program line is released, err is raised and no clock edge is ever produced.
- R4: A load of N bytes gives exactly 8*N data edges. Byte addresses ascend from 0, and bit 7 of each byte is sent first. The data line is stable for at least one system cycle before each rising edge.
- R5: After the last data bit, exactly TRAIL_CLKS further rising edges are produced, each with the data line high. A length of 0 produces only these trailing edges.
- R6: When the synchronised done line reads high after the trailing edges, ok is raised. If done stays low for DONE_TIMEOUT cycles, err is raised.
- R7: Consecutive rising edges are spaced exactly 2*DIV system cycles apart for the whole load, including across byte boundaries and into the trailing edges.
- R8: A start request is ignored while busy is high. A start request is accepted from the ok or err state and begins a new load.
- R9: Busy is low only in the idle, ok and err states, and ok and err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load request, one cycle |
| length | input | LEN_W | Bitstream length in bytes, sampled at start |
| mem_rd | output | 1 | Read strobe to bitstream memory |
| mem_addr | output | LEN_W | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| prog_n | output | 1 | Active-low program line to the target |
| init_n | input | 1 | Open-drain init line from the target (low = clearing) |
| done | input | 1 | Open-drain done line from the target |
| cclk | output | 1 | Gated configuration clock |
| cdata | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |

## Verification
The hardest cases to reach are the two failure paths and a start request made while a load is running. The bench models the target, and each scenario can tell that model to hold init low for ever or never to release done. This drives the controller into the matching timeout; a correct load is then run straight after, from the err state. To test the start request during a load, a second request is pulsed in the middle of the bit stream. The bench then checks that the program line went low only once and that the edge count still matches the length exactly. Edge spacing is measured on every edge, which shows up any pause waiting for the prefetched byte.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIDX_W    = $clog2(BYTE_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WINIT,
        ST_SHIFT,
        ST_TRAIL,
        ST_WDONE,
        ST_OK,
        ST_ERR
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    // Two flops per line; each line resets low (target busy / not done).
    for (genvar i = 0; i < W; i++) begin : g_line
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end

endmodule

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cfgl_feeder.sv
module cfgl_feeder
    import cfgl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LEN_W-1:0] length,
    input  logic             step,
    output logic             mem_rd,
    output logic [LEN_W-1:0] mem_addr,
    input  logic [7:0]       mem_rdata,
    output logic             nxt_bit,
    output logic             boundary,
    output logic             last,
    output logic             nvalid
);

    typedef struct packed {
        logic [BYTE_BITS-1:0] shreg;
        logic [BIDX_W-1:0]    bidx;
        logic [BYTE_BITS-1:0] nbyte;
        logic                 nvalid;
        logic                 pend;
        logic [LEN_W-1:0]     faddr;
        logic [LEN_W-1:0]     taken;
        logic [LEN_W-1:0]     len;
    } fd_t;

    localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(BYTE_BITS - 1);

    fd_t d, q;
    logic rd;

    always_comb begin
        d  = q;
        rd = !arm && !q.nvalid && !q.pend && (q.faddr < q.len);

        // Registered memory returns data one cycle after the strobe.
        if (q.pend) begin
            d.nbyte  = mem_rdata;
            d.nvalid = 1'b1;
            d.pend   = 1'b0;
        end
        if (rd) begin
            d.pend  = 1'b1;
            d.faddr = q.faddr + LEN_W'(1);
        end

        if (step) begin
            if (q.bidx == BIDX_LAST) begin
                d.shreg  = q.nbyte;
                d.nvalid = 1'b0;
                d.taken  = q.taken + LEN_W'(1);
                d.bidx   = '0;
            end else begin
                d.shreg = {q.shreg[BYTE_BITS-2:0], 1'b0};
                d.bidx  = q.bidx + BIDX_W'(1);
            end
        end

        if (arm) begin
            d.len    = length;
            d.faddr  = '0;
            d.taken  = '0;
            d.bidx   = BIDX_LAST;
            d.nvalid = 1'b0;
            d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd   = rd;
    assign mem_addr = q.faddr;
    assign boundary = (q.bidx == BIDX_LAST);
    assign nvalid   = q.nvalid;
    assign last     = boundary && (q.taken == q.len);
    assign nxt_bit  = boundary ? q.nbyte[BYTE_BITS-1] : q.shreg[BYTE_BITS-2];

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int DIV          = 2,
    parameter int PROG_CYCLES  = 16,
    parameter int INIT_TIMEOUT = 4096,
    parameter int DONE_TIMEOUT = 4096,
    parameter int TRAIL_CLKS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] length,
    output logic             mem_rd,
    output logic [LEN_W-1:0] mem_addr,
    input  logic [7:0]       mem_rdata,
    output logic             prog_n,
    input  logic             init_n,
    input  logic             done,
    output logic             cclk,
    output logic             cdata,
    output logic             busy,
    output logic             ok,
    output logic             err
);

    localparam int TMAX01 = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
    localparam int TMAX   = (TMAX01 > DONE_TIMEOUT) ? TMAX01 : DONE_TIMEOUT;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int TRW    = $clog2(TRAIL_CLKS + 1);

    typedef struct packed {
        cfgl_state_e    st;
        logic [TW-1:0]  tmr;
        logic [TRW-1:0] trn;
        logic           cclk;
        logic           cdata;
        logic           prog_n;
    } ctl_t;

    ctl_t d, q;

    logic init_s, done_s;
    logic tick, in_shift, in_trail;
    logic arm, step;
    logic nxt_bit, boundary, last, nvalid;

    cfgl_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({done, init_n}),
        .sync_out ({done_s, init_s})
    );

    assign in_shift = (q.st == ST_SHIFT);
    assign in_trail = (q.st == ST_TRAIL);

    cfgl_clkgen #(.DIV(DIV)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_shift || in_trail),
        .tick  (tick)
    );

    cfgl_feeder #(.LEN_W(LEN_W)) u_feeder (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .length    (length),
        .step      (step),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .nxt_bit   (nxt_bit),
        .boundary  (boundary),
        .last      (last),
        .nvalid    (nvalid)
    );

    always_comb begin
        d    = q;
        arm  = 1'b0;
        step = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_OK, ST_ERR: begin
                if (start) begin
                    d.st     = ST_PROG;
                    d.tmr    = '0;
                    d.prog_n = 1'b0;
                    d.cclk   = 1'b0;
                    d.cdata  = 1'b1;
                    arm      = 1'b1;
                end
            end
            ST_PROG: begin
                if (q.tmr == TW'(PROG_CYCLES - 1)) begin
                    d.prog_n = 1'b1;
                    d.st     = ST_WINIT;
                    d.tmr    = '0;
                end else begin
                    d.tmr = q.tmr + TW'(1);
                end
            end
            ST_WINIT: begin
                if (init_s && last) begin
                    d.st    = ST_TRAIL;
                    d.trn   = '0;
                    d.cdata = 1'b1;
                end else if (init_s && nvalid) begin
                    step    = 1'b1;
                    d.cdata = nxt_bit;
                    d.st    = ST_SHIFT;
                end else if (q.tmr == TW'(INIT_TIMEOUT - 1)) begin
                    d.st = ST_ERR;
                end else begin
                    d.tmr = q.tmr + TW'(1);
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.cclk) begin
                        d.cclk = 1'b1;
                    end else begin
                        d.cclk = 1'b0;
                        if (last) begin
                            d.st    = ST_TRAIL;
                            d.trn   = '0;
                            d.cdata = 1'b1;
                        end else begin
                            step    = 1'b1;
                            d.cdata = nxt_bit;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (!q.cclk) begin
                        d.cclk = 1'b1;
                        d.trn  = q.trn + TRW'(1);
                    end else begin
                        d.cclk = 1'b0;
                        if (q.trn == TRW'(TRAIL_CLKS)) begin
                            d.st  = ST_WDONE;
                            d.tmr = '0;
                        end
                    end
                end
            end
            ST_WDONE: begin
                if (done_s) begin
                    d.st = ST_OK;
                end else if (q.tmr == TW'(DONE_TIMEOUT - 1)) begin
                    d.st = ST_ERR;
                end else begin
                    d.tmr = q.tmr + TW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.tmr    <= '0;
            q.trn    <= '0;
            q.cclk   <= 1'b0;
            q.cdata  <= 1'b1;
            q.prog_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign prog_n = q.prog_n;
    assign cclk   = q.cclk;
    assign cdata  = q.cdata;
    assign busy   = !(q.st == ST_IDLE || q.st == ST_OK || q.st == ST_ERR);
    assign ok     = (q.st == ST_OK);
    assign err    = (q.st == ST_ERR);

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic cclk,
    input logic cdata,
    input logic busy,
    input logic ok,
    input logic err,
    input logic done_s,
    input logic step,
    input logic boundary,
    input logic nvalid,
    input logic in_trail
);

    assert_no_clk_in_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> !cclk);

    assert_prog_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> busy);

    assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(cdata));

    assert_trail_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_trail |-> cdata);

    assert_ok_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> $past(done_s));

    assert_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && boundary) |-> nvalid);

    assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));

    assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ok && !err));

endmodule

bind cfg_serial_loader cfgl_checker u_cfgl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .cclk     (cclk),
    .cdata    (cdata),
    .busy     (busy),
    .ok       (ok),
    .err      (err),
    .done_s   (done_s),
    .step     (step),
    .boundary (boundary),
    .nvalid   (nvalid),
    .in_trail (in_trail)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;

    localparam int LEN_W  = 16;
    localparam int DIV    = 2;
    localparam int PROGC  = 6;
    localparam int TRAILC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] length = '0;
    logic             mem_rd;
    logic [LEN_W-1:0] mem_addr;
    logic [7:0]       mem_rdata = 8'h00;
    logic             prog_n, cclk, cdata, busy, ok, err;
    logic             init_n = 1'b0;
    logic             done = 1'b0;

    always #2 clk = ~clk;

    cfg_serial_loader #(
        .LEN_W(LEN_W), .DIV(DIV), .PROG_CYCLES(PROGC),
        .INIT_TIMEOUT(100), .DONE_TIMEOUT(100), .TRAIL_CLKS(TRAILC)
    ) u_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .length(length),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .prog_n(prog_n), .init_n(init_n), .done(done),
        .cclk(cclk), .cdata(cdata), .busy(busy), .ok(ok), .err(err)
    );

    logic [7:0] mem [64];

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int nbits = 0, init_delay = -1, done_after = -1;
    int edges, bad_bits, bad_trail, early, pulses, low_cnt, low_width;
    int since_rel, last_edge, min_gap, max_gap;
    logic prev_cclk = 1'b0, prev_prog = 1'b1;

    task automatic clear_model();
        edges = 0; bad_bits = 0; bad_trail = 0; early = 0; pulses = 0;
        low_cnt = 0; low_width = 0; last_edge = -1;
        min_gap = 1000000; max_gap = 0;
    endtask

    // Target and memory model, all sampled and driven at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
        if (!prog_n) begin
            if (prev_prog) pulses++;
            low_cnt++;
            init_n <= 1'b0;
            done   <= 1'b0;
            since_rel = 0;
        end else begin
            if (!prev_prog) begin
                low_width = low_cnt;
                low_cnt = 0;
            end
            since_rel++;
            if (init_delay >= 0 && since_rel >= init_delay) init_n <= 1'b1;
        end
        if (cclk && !prev_cclk) begin
            if (!prog_n || !init_n) early++;
            if (edges < nbits) begin
                if (cdata !== mem[edges / 8][7 - (edges % 8)]) bad_bits++;
            end else if (cdata !== 1'b1) begin
                bad_trail++;
            end
            if (last_edge >= 0) begin
                if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
                if (cyc - last_edge > max_gap) max_gap = cyc - last_edge;
            end
            last_edge = cyc;
            edges++;
            if (done_after >= 0 && edges == nbits + done_after) done <= 1'b1;
        end
        prev_cclk = cclk;
        prev_prog = prog_n;
        if (cyc >= 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 73 + seed * 29 + 5) ^ (i << 3));
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input int len, input int idly, input int dafter);
        clear_model();
        nbits = len * 8; init_delay = idly; done_after = dafter;
        length = LEN_W'(len);
        pulse_start();
        check("R2 busy after start", int'(busy), 1);
        wait_idle();
    endtask

    task automatic check_good(input int len);
        check("R6 ok raised", int'(ok), 1);
        check("R9 err low on success", int'(err), 0);
        check("R9 busy low at end", int'(busy), 0);
        check("R4 edge count incl trail", edges, len * 8 + TRAILC);
        check("R4 data bits msb first", bad_bits, 0);
        check("R5 trail data high", bad_trail, 0);
        check("R3 no early edge", early, 0);
        check("R2 program low width", low_width, PROGC);
        if (edges > 1) begin
            check("R7 min edge gap", min_gap, 2 * DIV);
            check("R7 max edge gap", max_gap, 2 * DIV);
        end
    endtask

    task automatic t_reset();
        check("R1 prog_n high", int'(prog_n), 1);
        check("R1 cclk low", int'(cclk), 0);
        check("R1 busy low", int'(busy), 0);
        check("R1 ok low", int'(ok), 0);
        check("R1 err low", int'(err), 0);
    endtask

    task automatic t_basic();
        fill(1);
        do_load(5, 10, 2);
        check_good(5);
    endtask

    task automatic t_extremes();
        fill(2);
        mem[0] = 8'hFF;
        do_load(1, 3, 1);
        check_good(1);
        mem[0] = 8'h00;
        do_load(1, 20, 3);
        check_good(1);
        mem[0] = 8'h81;
        mem[1] = 8'h7E;
        do_load(2, 5, 2);
        check_good(2);
    endtask

    task automatic t_zero_len();
        do_load(0, 8, 2);
        check("R5 zero length only trail", edges, TRAILC);
        check("R5 zero length ok", int'(ok), 1);
        check("R5 zero length trail high", bad_trail, 0);
    endtask

    task automatic t_init_timeout();
        fill(3);
        do_load(4, -1, 2);
        check("R3 init timeout err", int'(err), 1);
        check("R3 init timeout ok low", int'(ok), 0);
        check("R3 no edges without init", edges, 0);
        check("R9 busy low after err", int'(busy), 0);
    endtask

    task automatic t_done_timeout();
        fill(4);
        do_load(3, 6, -1);
        check("R6 done timeout err", int'(err), 1);
        check("R6 done timeout ok low", int'(ok), 0);
        check("R6 edges before timeout", edges, 3 * 8 + TRAILC);
    endtask

    task automatic t_restart();
        fill(5);
        do_load(6, 12, 2);
        check("R8 restart from err accepted", pulses, 1);
        check_good(6);
        fill(6);
        do_load(3, 4, 2);
        check("R8 restart from ok accepted", pulses, 1);
        check_good(3);
    endtask

    task automatic t_busy_ignore();
        fill(7);
        clear_model();
        nbits = 8 * 8; init_delay = 7; done_after = 2;
        length = LEN_W'(8);
        pulse_start();
        repeat (80) @(negedge clk);
        check("R8 busy mid load", int'(busy), 1);
        pulse_start();
        wait_idle();
        check("R8 start while busy ignored", pulses, 1);
        check_good(8);
    endtask

    task automatic t_long();
        fill(8);
        do_load(16, 9, 3);
        check_good(16);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_zero_len();
        t_init_timeout();
        t_done_timeout();
        t_restart();
        t_busy_ignore();
        t_long();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule